// File: doc/BRIEF.md
# Set-Associative Cache Controller with Selectable Write Policy

This block sits between a processor and main memory. It keeps copies of whole memory lines in a set-associative store. The low address bits give a word within the line. The next bits pick one set directly. The remaining bits form a tag, which is compared in parallel against every way of that set. A read that hits returns its word in the cycle it is presented. A miss holds the processor off while the line is fetched from memory one word at a time.

A single parameter selects the write policy. In write-through mode, each write goes to memory and also updates any cached copy, and a write miss does not allocate a line. In write-back mode, writes allocate and touch only the cache, and each line carries a dirty flag. Only a dirty line is copied back to memory, and only when it is replaced. Within a set the controller fills empty ways first. After that it replaces the line that has gone longest without an access, which it tracks with a recency counter per line.

With a 32-bit address, 1024 sets and 256 words per line, the address splits into a 14-bit tag, a 10-bit set number and an 8-bit word offset. Sixteen ways give the full-size configuration. The parameter defaults are small so that the block can be checked thoroughly.

Top module: `sa_cache`

## Requirements
- R1: Word offset = `cpu_addr_i[OFF_W-1:0]`, set = the next `SET_W` bits, tag = the remaining upper bits. Two addresses that differ only in the offset share one line. Lines of one set never displace lines of another set.
- R2: A read always returns the value most recently written by the processor to that address, or the memory content if that address was never written.
- R3: A read hit raises `cpu_ready_o` in the same cycle as `cpu_valid_i`, with the data on `cpu_rdata_o`, and makes no memory request.
- R4: On a read miss, `cpu_ready_o` stays low while the line is refilled with exactly `WORDS` memory reads. The access then completes.
- R5: Write-through (`WRITE_BACK`=0): every write makes exactly one memory write of its address and data. The write completes in the cycle that write is acknowledged. A cached copy is updated at the same time.
- R6: Write-through: a write miss makes no memory reads and allocates no line, so a later read of that address misses.
- R7: Write-back (`WRITE_BACK`=1): a write hit updates only the cache. It makes no memory traffic, and memory keeps its old value.
- R8: Write-back: replacing a dirty line first writes all `WORDS` of its words to memory and then refills. Replacing a clean line makes no memory writes.
- R9: A miss fills an invalid way if the set has one. Otherwise it replaces the way that was accessed least recently.
- R10: `mem_req_o`, `mem_we_o` and `mem_addr_o` stay stable until `mem_ack_i`. Each acknowledged cycle transfers one word.
- R11: After reset there is no memory request and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | Processor request is a write |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory completes the word this cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ack |

## Verification
The hardest case to reach from the ports is the replacement of a dirty line that the recency counters have marked oldest. This needs a set that is completely full, a write-back write earlier in the sequence, and enough later accesses to age that line out. The bench builds this on purpose. It fills one set through every way, refreshes chosen lines, and then forces a miss. It compares the memory write count and the value in the memory model against the expected ones. A long sweep of writes and reads in scrambled address order then forces many evictions in every set, and checks each result against a reference memory. The bench runs a write-through and a write-back instance side by side with identical stimulus.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_THRU
  } cache_state_e;
endpackage

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup #(
  parameter int unsigned TAG_W = 28,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o
);
  // age 0 = most recent, WAYS-1 = oldest; ages of a set stay a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] old_age;

  assign old_age = age_q[set_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < old_age)
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/sa_cache_store.sv
module sa_cache_store #(
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned SETS   = 4,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned OFF_W = $clog2(WORDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SET_W-1:0]           set_i,
  output logic [WAYS-1:0][TAG_W-1:0] tags_o,
  output logic [WAYS-1:0]            valid_o,
  output logic [WAYS-1:0]            dirty_o,
  input  logic [WAY_W-1:0]           rd_way_i,
  input  logic [OFF_W-1:0]           rd_off_i,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic                       wr_en_i,
  input  logic                       dirty_en_i,
  input  logic [WAY_W-1:0]           wr_way_i,
  input  logic [OFF_W-1:0]           wr_off_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       tag_en_i,
  input  logic [WAY_W-1:0]           tag_way_i,
  input  logic [TAG_W-1:0]           tag_i
);
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS][WORDS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign tags_o[w] = tag_q[set_i][w];
  end
  assign valid_o   = valid_q[set_i];
  assign dirty_o   = dirty_q[set_i];
  assign rd_data_o = data_q[set_i][rd_way_i][rd_off_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (tag_en_i) begin
        valid_q[set_i][tag_way_i] <= 1'b1;
        dirty_q[set_i][tag_way_i] <= 1'b0;
      end else if (dirty_en_i) begin
        dirty_q[set_i][wr_way_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i)  data_q[set_i][wr_way_i][wr_off_i] <= wr_data_i;
    if (tag_en_i) tag_q[set_i][tag_way_i] <= tag_i;
  end
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned SETS       = 4,
  parameter int unsigned WORDS      = 4,
  parameter bit          WRITE_BACK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned SET_W   = $clog2(SETS);
  localparam int unsigned OFF_W   = $clog2(WORDS);
  localparam int unsigned TAG_LSB = OFF_W + SET_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;

  logic [OFF_W-1:0] off;
  logic [SET_W-1:0] set;
  logic [TAG_W-1:0] tag;
  assign off = cpu_addr_i[OFF_W-1:0];
  assign set = cpu_addr_i[TAG_LSB-1:OFF_W];
  assign tag = cpu_addr_i[ADDR_W-1:TAG_LSB];

  cache_state_e     state_q, state_d;
  logic [OFF_W-1:0] cnt_q;
  logic [WAY_W-1:0] vic_q;
  logic             last_w;

  logic [WAYS-1:0][TAG_W-1:0] tags;
  logic [WAYS-1:0]  valid, dirty;
  logic             hit;
  logic [WAY_W-1:0] hit_way, victim, rd_way, d_way;
  logic [OFF_W-1:0] rd_off, d_off;
  logic [DATA_W-1:0] rd_data, d_wdata;
  logic             d_we, dirty_we, t_we, touch;

  assign last_w = (cnt_q == OFF_W'(WORDS - 1));
  assign rd_way = (state_q == ST_EVICT) ? vic_q : hit_way;
  assign rd_off = (state_q == ST_EVICT) ? cnt_q : off;
  assign cpu_rdata_o = rd_data;

  sa_cache_store #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set),
    .tags_o     (tags),
    .valid_o    (valid),
    .dirty_o    (dirty),
    .rd_way_i   (rd_way),
    .rd_off_i   (rd_off),
    .rd_data_o  (rd_data),
    .wr_en_i    (d_we),
    .dirty_en_i (dirty_we),
    .wr_way_i   (d_way),
    .wr_off_i   (d_off),
    .wr_data_i  (d_wdata),
    .tag_en_i   (t_we),
    .tag_way_i  (vic_q),
    .tag_i      (tag)
  );

  sa_cache_lookup #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lookup (
    .tags_i  (tags),
    .valid_i (valid),
    .tag_i   (tag),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  sa_cache_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .set_i       (set),
    .touch_way_i (hit_way),
    .valid_i     (valid),
    .victim_o    (victim)
  );

  always_comb begin
    state_d     = state_q;
    cpu_ready_o = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    d_we        = 1'b0;
    dirty_we    = 1'b0;
    d_way       = hit_way;
    d_off       = off;
    d_wdata     = cpu_wdata_i;
    t_we        = 1'b0;
    touch       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_valid_i) begin
          if (cpu_we_i && !WRITE_BACK) begin
            state_d = ST_THRU;
          end else if (hit) begin
            cpu_ready_o = 1'b1;
            touch       = 1'b1;
            d_we        = cpu_we_i;
            dirty_we    = cpu_we_i && WRITE_BACK;
          end else if (WRITE_BACK && valid[victim] && dirty[victim]) begin
            state_d = ST_EVICT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {tags[vic_q], set, cnt_q};
        mem_wdata_o = rd_data;
        if (mem_ack_i && last_w) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {tag, set, cnt_q};
        if (mem_ack_i) begin
          d_we    = 1'b1;
          d_way   = vic_q;
          d_off   = cnt_q;
          d_wdata = mem_rdata_i;
          if (last_w) begin
            t_we    = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_THRU: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cpu_addr_i;
        mem_wdata_o = cpu_wdata_i;
        if (mem_ack_i) begin
          cpu_ready_o = 1'b1;
          d_we        = hit;
          touch       = hit;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        vic_q <= victim;
        cnt_q <= '0;
      end else if (mem_ack_i && (state_q == ST_EVICT || state_q == ST_FILL)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SETS       = 4,
  parameter int unsigned WORDS      = 4,
  parameter bit          WRITE_BACK = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_valid_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);
  localparam int unsigned TAG_LSB = $clog2(SETS) + $clog2(WORDS);

  a_r2_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_valid_i);

  a_r3_hit_no_traffic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && !cpu_we_i) |-> !mem_req_o);

  a_r4_refill_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !cpu_ready_o);

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r11_ack_only_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ack_i |-> mem_req_o);

  if (WRITE_BACK) begin : g_wb
    // R8: a write-back eviction never targets the line being requested
    a_r8_evict_other_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |->
        (mem_addr_o[ADDR_W-1:TAG_LSB] != cpu_addr_i[ADDR_W-1:TAG_LSB]));
  end else begin : g_wt
    a_r5_write_reaches_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_ready_o && cpu_valid_i && cpu_we_i) |->
        (mem_req_o && mem_we_o && mem_ack_i && mem_addr_o == cpu_addr_i));
  end
endmodule

bind sa_cache sa_cache_chk #(
  .ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .WRITE_BACK(WRITE_BACK)
) u_chk (.*);

// File: tb/sim_sa_cache.sv
`timescale 1ns/1ps
module sim_sa_cache;
  localparam int WORDS = 4;
  localparam int NADDR = 128;  // 3 tag bits, 2 set bits, 2 offset bits

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        v0 = 1'b0, v1 = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        rdy0, rdy1, mreq0, mreq1, mwe0, mwe1, mack0, mack1;
  logic [31:0] rd0, rd1, maddr0, maddr1, mwd0, mwd1, mrd0, mrd1;

  logic [31:0] mem0 [NADDR];
  logic [31:0] mem1 [NADDR];
  logic [31:0] ref_mem [NADDR];
  int rcnt0 = 0, rcnt1 = 0, wcnt0 = 0, wcnt1 = 0;
  int n_chk = 0, n_bad = 0, r10_viol = 0;
  bit finished = 0;

  sa_cache #(.WRITE_BACK(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_valid_i(v0), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_ready_o(rdy0), .cpu_rdata_o(rd0),
    .mem_req_o(mreq0), .mem_we_o(mwe0), .mem_addr_o(maddr0), .mem_wdata_o(mwd0),
    .mem_ack_i(mack0), .mem_rdata_i(mrd0));

  sa_cache #(.WRITE_BACK(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_valid_i(v1), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_ready_o(rdy1), .cpu_rdata_o(rd1),
    .mem_req_o(mreq1), .mem_we_o(mwe1), .mem_addr_o(maddr1), .mem_wdata_o(mwd1),
    .mem_ack_i(mack1), .mem_rdata_i(mrd1));

  function automatic logic [31:0] init_val(int a);
    return 32'h1000_0000 + a * 32'h0101_0003;
  endfunction

  initial begin
    for (int a = 0; a < NADDR; a++) begin
      mem0[a] = init_val(a);
      mem1[a] = init_val(a);
      ref_mem[a] = init_val(a);
    end
  end

  // memory models: acknowledge one cycle after a request is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mack0 <= 1'b0;
    else if (mreq0 && !mack0) begin
      mack0 <= 1'b1;
      if (mwe0) begin mem0[maddr0[6:0]] <= mwd0; wcnt0 <= wcnt0 + 1; end
      else begin mrd0 <= mem0[maddr0[6:0]]; rcnt0 <= rcnt0 + 1; end
    end else mack0 <= 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mack1 <= 1'b0;
    else if (mreq1 && !mack1) begin
      mack1 <= 1'b1;
      if (mwe1) begin mem1[maddr1[6:0]] <= mwd1; wcnt1 <= wcnt1 + 1; end
      else begin mrd1 <= mem1[maddr1[6:0]]; rcnt1 <= rcnt1 + 1; end
    end else mack1 <= 1'b0;
  end

  // R10 monitor: a pending request keeps its address until acknowledged
  logic        p_req0 = 0, p_ack0 = 0, p_req1 = 0, p_ack1 = 0;
  logic [31:0] p_a0 = '0, p_a1 = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req0 && !p_ack0 && !(mreq0 && maddr0 == p_a0)) r10_viol++;
      if (p_req1 && !p_ack1 && !(mreq1 && maddr1 == p_a1)) r10_viol++;
    end
    p_req0 = mreq0; p_ack0 = mack0; p_a0 = maddr0;
    p_req1 = mreq1; p_ack1 = mack1; p_a1 = maddr1;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int lat0, lat1;
  logic [31:0] got0, got1;

  task automatic access(bit w, logic [31:0] a, logic [31:0] d);
    int n;
    bit t0, t1;
    we = w; addr = a; wdata = d; v0 = 1'b1; v1 = 1'b1;
    n = 0; lat0 = 0; lat1 = 0;
    while ((v0 || v1) && n < 2000) begin
      @(negedge clk);
      n++;
      t0 = v0 && rdy0;
      t1 = v1 && rdy1;
      if (t0) begin got0 = rd0; lat0 = n; end
      if (t1) begin got1 = rd1; lat1 = n; end
      @(posedge clk); #1;
      if (t0) v0 = 1'b0;
      if (t1) v1 = 1'b0;
    end
    if (v0 || v1) begin
      chk(0, "R2", "access hung", 32'(n), 0);
      v0 = 1'b0; v1 = 1'b0;
    end
    if (w) ref_mem[a[6:0]] = d;
  endtask

  task automatic rd_chk(logic [31:0] a, string req);
    access(1'b0, a, '0);
    chk(got0 == ref_mem[a[6:0]], req, "wb read data", got0, ref_mem[a[6:0]]);
    chk(got1 == ref_mem[a[6:0]], req, "wt read data", got1, ref_mem[a[6:0]]);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r0, w0, r1, w1;
    logic [31:0] old1;
    repeat (3) @(posedge clk);
    #1;
    // R11: idle after reset
    chk(!mreq0 && !mreq1, "R11", "no request in reset", {mreq0, mreq1}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!mreq0 && !mreq1 && !rdy0 && !rdy1, "R11", "idle after reset", {mreq0, mreq1}, 0);

    // R4: first read misses and refills one full line; R11 no line valid yet
    r0 = rcnt0; r1 = rcnt1;
    rd_chk(32'h00, "R4");
    chk(lat0 > 1 && lat1 > 1, "R11", "cold read misses", 32'(lat0), 2);
    chk(rcnt0 - r0 == WORDS, "R4", "wb refill reads", 32'(rcnt0 - r0), WORDS);
    chk(rcnt1 - r1 == WORDS, "R4", "wt refill reads", 32'(rcnt1 - r1), WORDS);

    // R1 / R3: neighbouring word of the same line hits in one cycle
    r0 = rcnt0; r1 = rcnt1;
    rd_chk(32'h01, "R3");
    chk(lat0 == 1 && lat1 == 1, "R3", "hit latency", 32'(lat0), 1);
    chk(rcnt0 == r0 && rcnt1 == r1, "R1", "same line no traffic", 32'(rcnt0 - r0), 0);

    // R7 / R5: write hit
    w0 = wcnt0; w1 = wcnt1;
    access(1'b1, 32'h01, 32'hDEAD_0001);
    chk(wcnt0 == w0, "R7", "wb hit no mem write", 32'(wcnt0 - w0), 0);
    chk(mem0[1] == init_val(1), "R7", "wb memory unchanged", mem0[1], init_val(1));
    chk(wcnt1 - w1 == 1, "R5", "wt one mem write", 32'(wcnt1 - w1), 1);
    chk(mem1[1] == 32'hDEAD_0001, "R5", "wt memory updated", mem1[1], 32'hDEAD_0001);
    rd_chk(32'h01, "R5");
    chk(lat1 == 1, "R5", "wt cached copy hit", 32'(lat1), 1);

    // R6: write-through write miss does not allocate
    r1 = rcnt1; w1 = wcnt1;
    access(1'b1, 32'h14, 32'hBEEF_0014);
    chk(rcnt1 == r1 && wcnt1 - w1 == 1, "R6", "wt miss only writes", 32'(rcnt1 - r1), 0);
    rd_chk(32'h14, "R6");
    chk(lat1 > 1, "R6", "wt no allocate", 32'(lat1), 2);

    // R9: fill set 0 with tags 1..3, refresh tag 0, tag 4 replaces tag 1
    rd_chk(32'h10, "R9"); rd_chk(32'h20, "R9"); rd_chk(32'h30, "R9");
    rd_chk(32'h00, "R9");
    chk(lat0 == 1 && lat1 == 1, "R9", "tag0 still cached", 32'(lat0), 1);
    w0 = wcnt0;
    rd_chk(32'h40, "R8");
    chk(wcnt0 == w0, "R8", "clean victim no write", 32'(wcnt0 - w0), 0);
    rd_chk(32'h02, "R9"); chk(lat0 == 1 && lat1 == 1, "R9", "tag0 kept", 32'(lat0), 1);
    rd_chk(32'h21, "R9"); chk(lat0 == 1 && lat1 == 1, "R9", "tag2 kept", 32'(lat0), 1);
    rd_chk(32'h31, "R9"); chk(lat0 == 1 && lat1 == 1, "R9", "tag3 kept", 32'(lat0), 1);
    rd_chk(32'h11, "R9"); chk(lat0 > 1 && lat1 > 1, "R9", "lru tag1 evicted", 32'(lat0), 2);
    // recency now tag1, tag3, tag2, tag0: tag 5 evicts dirty tag 0 in u0
    w0 = wcnt0; w1 = wcnt1;
    rd_chk(32'h50, "R8");
    chk(wcnt0 - w0 == WORDS, "R8", "dirty victim written back", 32'(wcnt0 - w0), WORDS);
    chk(mem0[1] == 32'hDEAD_0001, "R8", "written back value", mem0[1], 32'hDEAD_0001);
    chk(wcnt1 == w1, "R8", "wt never writes back", 32'(wcnt1 - w1), 0);
    rd_chk(32'h01, "R2");

    // R2 / R1: sweep of writes and reads in scrambled order
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NADDR; i++)
        access(1'b1, 32'((i * 37 + p * 5) % NADDR), 32'hA000_0000 + 32'(i * 977 + p));
      for (int i = 0; i < NADDR; i++)
        rd_chk(32'((i * 53 + 11 + p) % NADDR), "R2");
    end
    for (int i = 0; i < NADDR; i++) begin
      old1 = mem1[i];
      chk(old1 == ref_mem[i], "R5", "wt memory matches", old1, ref_mem[i]);
    end
    chk(r10_viol == 0, "R10", "request held until ack", 32'(r10_viol), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule